// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block is the bus-master side of a processor that answers an accepted maskable interrupt. An accept pulse arrives from the core's instruction-boundary logic while the interrupt request is high. The sequencer waits until any bus cycle already on the bus has finished. It then runs two read cycles back to back under bus lock. Each cycle starts with a single-clock address strobe and ends on the system's ready strobe. The first read is only a protocol formality, and its data is thrown away. The low data byte of the second read is the interrupt vector, which the sequencer presents together with a one-clock valid pulse.

Both cycles drive the cycle-type outputs (data/control, memory/IO, write/read) low and put zero on the quadword address. The byte-enable pattern (active low) tells the two cycles apart. A fixed number of idle clocks, set by a parameter, separates the ready of the first cycle from the strobe of the second. Lock stays asserted through that gap.

The vector output is a plain valid pulse with no ready input. The consumer must take the vector in the clock where the valid pulse is high, because no back-pressure can be applied and the vector is offered only once.

Top module: `intack_seq`

## Requirements
- R1: During and right after synchronous active-high reset the sequencer is idle. Strobe, lock and vector-valid are low, the byte enables read FFh, and data/control, memory/IO and write/read are all high.
- R2: A sequence starts only when the accept pulse is sampled while the interrupt request is high. An accept pulse sampled with the request low is ignored, and so is one sampled while a sequence is already running.
- R3: While the prior-cycle busy input is high the first strobe is held off. The first strobe appears in the clock after busy is sampled low.
- R4: Each of the two cycles begins with an address strobe exactly one clock long. Throughout each cycle data/control, memory/IO and write/read are low and the address is zero.
- R5: The byte enables are EFh for the whole first cycle and FEh for the whole second cycle (active low, so only byte 0 is enabled in the second). Outside the two cycles they are FFh.
- R6: A cycle holds its outputs until ready is sampled high in a clock after its strobe clock. A ready that is high during the strobe clock itself is ignored.
- R7: Exactly GAP_CLKS idle clocks (at least 1) pass between the clock in which the first cycle's ready is sampled and the second strobe. During the gap the byte enables are FFh and no strobe is driven.
- R8: Lock is high from the first strobe until the second cycle's ready is sampled, and it stays high through the idle gap.
- R9: On the second cycle's ready, bits 7:0 of the data bus are captured. The vector appears with a one-clock valid pulse in the next clock, with lock already low, and the sequencer is idle again. The data returned by the first cycle never reaches the vector output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Maskable interrupt request level |
| accept | input | 1 | One-clock pulse: core takes the interrupt now |
| bus_busy | input | 1 | A previously started bus cycle is still running |
| rdy | input | 1 | Bus ready strobe ending the current cycle |
| bus_data_lo | input | VEC_W | Low byte of the read data bus |
| bus_ads | output | 1 | Address strobe, one clock per cycle |
| bus_lock | output | 1 | Bus lock across the read pair |
| bus_dc | output | 1 | Data/control cycle type |
| bus_mio | output | 1 | Memory/IO cycle type |
| bus_wr | output | 1 | Write/read cycle type |
| bus_be | output | 8 | Byte enables, active low |
| bus_addr | output | ADDR_W | Quadword address |
| vec_valid | output | 1 | One-clock pulse: vector is valid |
| vec_data | output | VEC_W | Captured interrupt vector |

## Verification
The bench holds the busy input high for varying lengths and checks that no strobe appears before busy drops. A design that ignored busy would issue the first read on top of another cycle. It raises ready in the strobe clock and expects the cycle to keep going, since an early acceptance would cut the first read to a single clock. It counts the idle clocks of the gap exactly: a counter that is off by one would shorten or stretch the gap, and skipping it would break the minimum separation. It puts a recognisable byte on the bus in the first read, so a design that latched on the wrong ready would deliver that byte as the vector. It also pulses accept with the request low and again in the middle of a sequence, so a design that did not filter these would start a spurious extra pair of reads.

// File: rtl/intack_pkg.sv
package intack_pkg;
  localparam int BE_W = 8;
  localparam logic [BE_W-1:0] BE_FIRST  = 8'hEF;
  localparam logic [BE_W-1:0] BE_SECOND = 8'hFE;
  localparam logic [BE_W-1:0] BE_NONE   = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_ADS1,
    ST_WAIT1,
    ST_GAP,
    ST_ADS2,
    ST_WAIT2
  } ack_state_e;
endpackage

// File: rtl/intack_gap_cnt.sv
module intack_gap_cnt #(
  parameter int GAP_CLKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(GAP_CLKS - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/intack_vec_cap.sv
module intack_vec_cap #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [VEC_W-1:0] din,
  output logic             valid,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      vec   <= '0;
    end else begin
      valid <= capture;
      if (capture) vec <= din;
    end
  end
endmodule

// File: rtl/intack_fsm.sv
module intack_fsm
  import intack_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_req,
  input  logic       accept,
  input  logic       bus_busy,
  input  logic       rdy,
  input  logic       gap_done,
  output ack_state_e state,
  output logic       gap_load,
  output logic       cap_en
);
  ack_state_e nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt      = state;
    gap_load = 1'b0;
    cap_en   = 1'b0;
    case (state)
      ST_IDLE:  if (accept && irq_req) nxt = ST_PEND;
      ST_PEND:  if (!bus_busy) nxt = ST_ADS1;
      ST_ADS1:  nxt = ST_WAIT1;
      ST_WAIT1: if (rdy) begin
                  nxt      = ST_GAP;
                  gap_load = 1'b1;
                end
      ST_GAP:   if (gap_done) nxt = ST_ADS2;
      ST_ADS2:  nxt = ST_WAIT2;
      ST_WAIT2: if (rdy) begin
                  nxt    = ST_IDLE;
                  cap_en = 1'b1;
                end
      default:  nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/intack_bus_drv.sv
module intack_bus_drv
  import intack_pkg::*;
#(
  parameter int ADDR_W = 29
) (
  input  ack_state_e        state,
  output logic              ads,
  output logic              lock,
  output logic              dc,
  output logic              mio,
  output logic              wr,
  output logic [BE_W-1:0]   be,
  output logic [ADDR_W-1:0] addr
);
  logic cyc1, cyc2, in_cyc;

  always_comb begin
    cyc1   = (state == ST_ADS1) || (state == ST_WAIT1);
    cyc2   = (state == ST_ADS2) || (state == ST_WAIT2);
    in_cyc = cyc1 || cyc2;
    ads    = (state == ST_ADS1) || (state == ST_ADS2);
    lock   = in_cyc || (state == ST_GAP);
    if (cyc1)      be = BE_FIRST;
    else if (cyc2) be = BE_SECOND;
    else           be = BE_NONE;
    dc   = !in_cyc;
    mio  = !in_cyc;
    wr   = !in_cyc;
    addr = '0;
  end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int ADDR_W   = 29,
  parameter int VEC_W    = 8,
  parameter int GAP_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_req,
  input  logic              accept,
  input  logic              bus_busy,
  input  logic              rdy,
  input  logic [VEC_W-1:0]  bus_data_lo,
  output logic              bus_ads,
  output logic              bus_lock,
  output logic              bus_dc,
  output logic              bus_mio,
  output logic              bus_wr,
  output logic [BE_W-1:0]   bus_be,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_data
);
  ack_state_e state;
  logic       gap_load, gap_done, cap_en;

  intack_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .accept   (accept),
    .bus_busy (bus_busy),
    .rdy      (rdy),
    .gap_done (gap_done),
    .state    (state),
    .gap_load (gap_load),
    .cap_en   (cap_en)
  );

  intack_gap_cnt #(.GAP_CLKS(GAP_CLKS)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .load (gap_load),
    .done (gap_done)
  );

  intack_vec_cap #(.VEC_W(VEC_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .capture (cap_en),
    .din     (bus_data_lo),
    .valid   (vec_valid),
    .vec     (vec_data)
  );

  intack_bus_drv #(.ADDR_W(ADDR_W)) u_drv (
    .state (state),
    .ads   (bus_ads),
    .lock  (bus_lock),
    .dc    (bus_dc),
    .mio   (bus_mio),
    .wr    (bus_wr),
    .be    (bus_be),
    .addr  (bus_addr)
  );
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
  parameter int ADDR_W = 29
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_busy,
  input logic              rdy,
  input logic              bus_ads,
  input logic              bus_lock,
  input logic              bus_dc,
  input logic              bus_mio,
  input logic              bus_wr,
  input logic [7:0]        bus_be,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              vec_valid
);
  AST_ADS_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    bus_ads |=> !bus_ads); // R4
  AST_CYCLE_TYPE: assert property (@(posedge clk) disable iff (rst)
    bus_ads |-> (!bus_dc && !bus_mio && !bus_wr && bus_addr == '0)); // R4
  AST_BE_PATTERN: assert property (@(posedge clk) disable iff (rst)
    bus_ads |-> (bus_be == 8'hEF || bus_be == 8'hFE)); // R5
  AST_FIRST_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    (bus_ads && bus_be == 8'hEF) |-> !$past(bus_busy)); // R3
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
    (bus_ads && bus_be == 8'hFE) |-> (!$past(rdy) && $past(bus_lock))); // R7
  AST_LOCK_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    bus_ads |-> bus_lock); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid); // R9
  AST_VALID_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (!bus_lock && $past(bus_lock))); // R9
endmodule

bind intack_seq intack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/intack_seq_tb.sv
module intack_seq_tb;
  localparam int GAP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 1'b0, accept = 1'b0, bus_busy = 1'b0, rdy = 1'b0;
  logic [7:0]  bus_data_lo = 8'h00;
  logic        bus_ads, bus_lock, bus_dc, bus_mio, bus_wr, vec_valid;
  logic [7:0]  bus_be, vec_data;
  logic [28:0] bus_addr;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  intack_seq #(.GAP_CLKS(GAP)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares produced vectors with the scoreboard queue (R9)
  always @(negedge clk) begin
    if (!rst && vec_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected vector", vec_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(vec_data == e, "R9 vector value", vec_data, e);
      end
    end
  end

  task automatic cyc_chk(input logic [7:0] be_exp, input string req);
    chk(bus_be == be_exp, {req, " byte enables"}, bus_be, be_exp);
    chk(!bus_dc && !bus_mio && !bus_wr && bus_addr == 0, "R4 cycle type and address",
        {bus_dc, bus_mio, bus_wr, 32'(bus_addr)}, 0);
    chk(bus_lock, "R8 lock during cycle", bus_lock, 1);
  endtask

  task automatic run_ack(input logic [7:0] vec, input logic [7:0] junk, input int busy_n,
                         input int w1, input int w2, input bit rdy_in_ads, input bit accept_mid);
    int n;
    @(negedge clk);
    irq_req = 1'b1; accept = 1'b1; bus_busy = (busy_n > 0);
    @(negedge clk);
    accept = 1'b0;
    for (int i = 0; i < busy_n; i++) begin
      chk(!bus_ads, "R3 no strobe while busy", bus_ads, 0);
      @(negedge clk);
    end
    bus_busy = 1'b0;
    chk(!bus_ads, "R3 pending before strobe", bus_ads, 0);
    @(negedge clk);
    chk(bus_ads, "R3 strobe after busy drops", bus_ads, 1);
    cyc_chk(8'hEF, "R5 first");
    exp_q.push_back(vec);
    if (rdy_in_ads) begin rdy = 1'b1; bus_data_lo = junk; end
    @(negedge clk);
    rdy = 1'b0;
    chk(!bus_ads, "R4 strobe one clock", bus_ads, 0);
    cyc_chk(8'hEF, "R6 held first");
    if (accept_mid) accept = 1'b1;
    for (int i = 0; i < w1; i++) begin
      @(negedge clk);
      accept = 1'b0;
      cyc_chk(8'hEF, "R6 wait first");
    end
    rdy = 1'b1; bus_data_lo = junk;
    @(negedge clk);
    rdy = 1'b0; accept = 1'b0;
    n = 0;
    while (!bus_ads && n < 20) begin
      chk(bus_lock && bus_be == 8'hFF, "R7 gap lock and enables", {bus_lock, bus_be}, 9'h1FF);
      n++;
      @(negedge clk);
    end
    chk(n == GAP, "R7 gap length", n, GAP);
    chk(bus_ads, "R4 second strobe", bus_ads, 1);
    cyc_chk(8'hFE, "R5 second");
    @(negedge clk);
    chk(!bus_ads, "R4 second strobe one clock", bus_ads, 0);
    cyc_chk(8'hFE, "R6 held second");
    for (int i = 0; i < w2; i++) begin
      @(negedge clk);
      cyc_chk(8'hFE, "R6 wait second");
    end
    rdy = 1'b1; bus_data_lo = vec;
    @(negedge clk);
    rdy = 1'b0; bus_data_lo = junk; irq_req = 1'b0;
    chk(vec_valid && !bus_lock, "R9 valid with lock released", {vec_valid, bus_lock}, 2'b10);
    chk(bus_be == 8'hFF, "R5 idle enables", bus_be, 8'hFF);
    @(negedge clk);
    chk(!vec_valid, "R9 valid one clock", vec_valid, 0);
    for (int i = 0; i < 3; i++) begin
      chk(!bus_ads && !bus_lock, "R2 no extra sequence", {bus_ads, bus_lock}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_ads && !bus_lock && !vec_valid && bus_be == 8'hFF && bus_dc && bus_mio && bus_wr,
        "R1 reset state", {bus_ads, bus_lock, vec_valid, bus_be}, 11'h0FF);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_ads && !bus_lock && bus_be == 8'hFF, "R1 idle after reset",
        {bus_ads, bus_lock, bus_be}, 10'h0FF);
    // R2: accept with request low
    accept = 1'b1; irq_req = 1'b0;
    @(negedge clk);
    accept = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!bus_ads && !bus_lock, "R2 accept without request ignored", {bus_ads, bus_lock}, 0);
      @(negedge clk);
    end
    run_ack(8'h21, 8'hA5, 0, 0, 0, 1'b0, 1'b0);
    run_ack(8'h7E, 8'h3C, 3, 2, 1, 1'b1, 1'b0);
    run_ack(8'hC4, 8'h99, 1, 1, 3, 1'b0, 1'b1);
    run_ack(8'h00, 8'hFF, 5, 0, 0, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all vectors delivered", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule